// File: doc/BRIEF.md
# Integer Multiply-Accumulate Unit

This unit multiplies two integer source operands and can combine the product with an accumulator operand. It either returns the product, adds the product to the accumulator, or subtracts the product from it. The operands can be treated as signed or unsigned. The result can be produced for a single-word destination or for a double-word destination. In single-word mode the low word of the exact result is returned. In double-word mode the full result is returned. An optional saturation mode clamps an out-of-range result to the nearest value the destination can represent. An overflow flag reports every out-of-range result, whether or not saturation is enabled.

One datapath serves every form. Both operands are extended by one bit, so a single signed multiplier covers both the signed and the unsigned case. Accumulation is done at two bits above double width, which keeps the unsaturated value exact. A final stage checks that value against the destination range and clamps it when needed. A parameter inserts a pipeline register after the multiplier. The output is always registered. The latency is therefore one or two cycles.

Top module: `imac_unit`

## Requirements
- R1: With `op` = 2'b00 (multiply; the code 2'b11 behaves the same) and `wide` = 0, `result[31:0]` is the low 32 bits of the product and `result[63:32]` is zero.
- R2: With `wide` = 1, `result[63:0]` is the full 64-bit product of the operands. The operands are read as two's complement when `is_signed` = 1 and as unsigned when `is_signed` = 0.
- R3: With `op` = 2'b01 (multiply-add), the product is added to the accumulator. In narrow mode the accumulator is `acc[31:0]`, sign- or zero-extended. In wide mode it is all of `acc[63:0]`.
- R4: With `op` = 2'b10 (multiply-subtract), the product is subtracted from the accumulator. The accumulator is selected as in R3.
- R5: `ovf` is 1 exactly when the exact, unsaturated result lies outside the range of the destination. That range is 32 or 64 bits, signed or unsigned. This holds whatever the value of `sat_en`.
- R6: Signed, narrow, `sat_en` = 1: a result above the range gives `result[31:0]` = 0x7FFFFFFF, and a result below the range gives 0x80000000.
- R7: Signed, wide, `sat_en` = 1: an out-of-range result clamps to 0x7FFFFFFFFFFFFFFF or to 0x8000000000000000.
- R8: Unsigned, `sat_en` = 1: a result above the range clamps to all ones across the destination width. A negative result (possible only with multiply-subtract) clamps to zero.
- R9: `out_valid` rises exactly 1+MUL_REG cycles after an `in_valid` cycle and is otherwise 0. Reset clears `out_valid`, `result` and `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| src_a | input | XLEN | First multiplicand |
| src_b | input | XLEN | Second multiplicand |
| acc | input | 2*XLEN | Accumulator operand |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| sat_en | input | 1 | Clamp out-of-range results |
| op | input | 2 | 00 multiply, 01 multiply-add, 10 multiply-subtract, 11 multiply |
| wide | input | 1 | 1: double-word destination, 0: single word |
| out_valid | output | 1 | Result valid |
| result | output | 2*XLEN | Low word on bits XLEN-1:0, high word above |
| ovf | output | 1 | Unsaturated result did not fit the destination |

## Verification
The bench builds the unit with XLEN = 32 and MUL_REG = 1. This is the two-cycle configuration, where control and accumulator must travel through the multiplier stage alongside the product. The 32-bit width brings the exact saturation boundaries into reach: 0x7FFFFFFF, 0x80000000 and the 64-bit extremes. It also makes the unsigned all-ones product (0xFFFFFFFF squared) reachable, which only the widened accumulation width can hold without loss. Multiply-subtract underflow in unsigned mode is checked with and without clamping.

// File: rtl/imac_pkg.sv
package imac_pkg;

   typedef enum logic [1:0] {
      OP_MUL  = 2'b00,
      OP_MADD = 2'b01,
      OP_MSUB = 2'b10,
      OP_RSVD = 2'b11
   } mac_op_e;

   typedef struct packed {
      logic    sg;
      logic    sat;
      mac_op_e op;
      logic    wide;
   } mac_ctrl_t;

endpackage

// File: rtl/imac_mult.sv
module imac_mult
   import imac_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int MUL_REG = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      vld_i,
   input  logic [XLEN-1:0]           a_i,
   input  logic [XLEN-1:0]           b_i,
   input  logic [2*XLEN-1:0]         acc_i,
   input  mac_ctrl_t                 ctrl_i,
   output logic                      vld_o,
   output logic signed [2*XLEN+1:0]  prod_o,
   output logic [2*XLEN-1:0]         acc_o,
   output mac_ctrl_t                 ctrl_o
);
   localparam int PW = 2*XLEN + 2;

   logic signed [XLEN:0]  ax, bx;
   logic signed [PW-1:0]  prod_c;

   // one extra bit per operand lets a single signed multiplier serve both modes
   assign ax     = {ctrl_i.sg & a_i[XLEN-1], a_i};
   assign bx     = {ctrl_i.sg & b_i[XLEN-1], b_i};
   assign prod_c = PW'(ax) * PW'(bx);

   generate
      if (MUL_REG != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_o  <= 1'b0;
               prod_o <= '0;
               acc_o  <= '0;
               ctrl_o <= '0;
            end else begin
               vld_o <= vld_i;
               if (vld_i) begin
                  prod_o <= prod_c;
                  acc_o  <= acc_i;
                  ctrl_o <= ctrl_i;
               end
            end
         end
      end else begin : g_comb
         assign vld_o  = vld_i;
         assign prod_o = prod_c;
         assign acc_o  = acc_i;
         assign ctrl_o = ctrl_i;
      end
   endgenerate

endmodule

// File: rtl/imac_accum.sv
module imac_accum
   import imac_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic signed [2*XLEN+1:0] prod_i,
   input  logic [2*XLEN-1:0]        acc_i,
   input  mac_ctrl_t                ctrl_i,
   output logic signed [2*XLEN+1:0] sum_o
);
   localparam int EW = 2*XLEN + 2;

   logic signed [EW-1:0] acc_narrow, acc_wide, acc_x;

   assign acc_narrow = {{(XLEN+2){ctrl_i.sg & acc_i[XLEN-1]}}, acc_i[XLEN-1:0]};
   assign acc_wide   = {{2{ctrl_i.sg & acc_i[2*XLEN-1]}}, acc_i};
   assign acc_x      = ctrl_i.wide ? acc_wide : acc_narrow;

   always_comb begin
      unique case (ctrl_i.op)
         OP_MADD: sum_o = acc_x + prod_i;
         OP_MSUB: sum_o = acc_x - prod_i;
         default: sum_o = prod_i;
      endcase
   end

endmodule

// File: rtl/imac_sat.sv
module imac_sat
   import imac_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic signed [2*XLEN+1:0] val_i,
   input  mac_ctrl_t                ctrl_i,
   output logic [2*XLEN-1:0]        res_o,
   output logic                     ovf_o
);
   localparam int EW = 2*XLEN + 2;
   localparam int DW = 2*XLEN;

   logic neg, fit_sn, fit_sw, fit_un, fit_uw, fits;
   logic [DW-1:0] wrap, clamp;

   assign neg = val_i[EW-1];

   // signed fits when every bit from the destination sign bit upward agrees
   assign fit_sn = (&val_i[EW-1:XLEN-1]) | ~(|val_i[EW-1:XLEN-1]);
   assign fit_sw = (&val_i[EW-1:DW-1])   | ~(|val_i[EW-1:DW-1]);
   // unsigned fits when nothing is set above the destination
   assign fit_un = ~(|val_i[EW-1:XLEN]);
   assign fit_uw = ~(|val_i[EW-1:DW]);

   always_comb begin
      unique case ({ctrl_i.sg, ctrl_i.wide})
         2'b11:   fits = fit_sw;
         2'b10:   fits = fit_sn;
         2'b01:   fits = fit_uw;
         default: fits = fit_un;
      endcase
   end

   assign wrap = ctrl_i.wide ? val_i[DW-1:0] : {{XLEN{1'b0}}, val_i[XLEN-1:0]};

   always_comb begin
      clamp = '0;
      if (ctrl_i.sg) begin
         if (ctrl_i.wide) clamp = neg ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
         else             clamp = neg ? {{XLEN{1'b0}}, 1'b1, {(XLEN-1){1'b0}}}
                                      : {{XLEN{1'b0}}, 1'b0, {(XLEN-1){1'b1}}};
      end else if (!neg) begin
         if (ctrl_i.wide) clamp = '1;
         else             clamp = {{XLEN{1'b0}}, {XLEN{1'b1}}};
      end
   end

   assign ovf_o = ~fits;
   assign res_o = (ctrl_i.sat && !fits) ? clamp : wrap;

endmodule

// File: rtl/imac_unit.sv
module imac_unit
   import imac_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int MUL_REG = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [XLEN-1:0]     src_a,
   input  logic [XLEN-1:0]     src_b,
   input  logic [2*XLEN-1:0]   acc,
   input  logic                is_signed,
   input  logic                sat_en,
   input  logic [1:0]          op,
   input  logic                wide,
   output logic                out_valid,
   output logic [2*XLEN-1:0]   result,
   output logic                ovf
);
   localparam int EW = 2*XLEN + 2;

   generate
      if (XLEN < 4) begin : g_bad_xlen
         $error("imac_unit: XLEN must be at least 4");
      end
      if (MUL_REG != 0 && MUL_REG != 1) begin : g_bad_reg
         $error("imac_unit: MUL_REG must be 0 or 1");
      end
   endgenerate

   mac_ctrl_t            ctrl_in, ctrl_m;
   logic                 vld_m;
   logic signed [EW-1:0] prod_m, sum_m;
   logic [2*XLEN-1:0]    acc_m, res_m;
   logic                 ovf_m;

   assign ctrl_in = '{sg: is_signed, sat: sat_en, op: mac_op_e'(op), wide: wide};

   imac_mult #(.XLEN(XLEN), .MUL_REG(MUL_REG)) u_mult (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (in_valid),
      .a_i    (src_a),
      .b_i    (src_b),
      .acc_i  (acc),
      .ctrl_i (ctrl_in),
      .vld_o  (vld_m),
      .prod_o (prod_m),
      .acc_o  (acc_m),
      .ctrl_o (ctrl_m)
   );

   imac_accum #(.XLEN(XLEN)) u_accum (
      .prod_i (prod_m),
      .acc_i  (acc_m),
      .ctrl_i (ctrl_m),
      .sum_o  (sum_m)
   );

   imac_sat #(.XLEN(XLEN)) u_sat (
      .val_i  (sum_m),
      .ctrl_i (ctrl_m),
      .res_o  (res_m),
      .ovf_o  (ovf_m)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         ovf       <= 1'b0;
      end else begin
         out_valid <= vld_m;
         if (vld_m) begin
            result <= res_m;
            ovf    <= ovf_m;
         end
      end
   end

endmodule

// File: rtl/imac_unit_chk.sv
module imac_unit_chk #(
   parameter int XLEN    = 32,
   parameter int MUL_REG = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              is_signed,
   input logic              sat_en,
   input logic              wide,
   input logic              out_valid,
   input logic [2*XLEN-1:0] result,
   input logic              ovf
);
   localparam int LAT = 1 + MUL_REG;

   logic [LAT-1:0] vld_sh;
   logic [LAT-1:0] sg_sh, sat_sh, wd_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_sh <= '0;
         sg_sh  <= '0;
         sat_sh <= '0;
         wd_sh  <= '0;
      end else begin
         vld_sh <= LAT'({vld_sh, in_valid});
         sg_sh  <= LAT'({sg_sh, is_signed});
         sat_sh <= LAT'({sat_sh, sat_en});
         wd_sh  <= LAT'({wd_sh, wide});
      end
   end

   wire sg_d  = sg_sh[LAT-1];
   wire sat_d = sat_sh[LAT-1];
   wire wd_d  = wd_sh[LAT-1];

   // R9
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vld_sh[LAT-1]);

   // R1
   narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !wd_d) |-> (result[2*XLEN-1:XLEN] == '0));

   // R6
   signed_sat_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ovf && sg_d && sat_d && !wd_d) |->
      (result[XLEN-1:0] == {1'b0, {(XLEN-1){1'b1}}} || result[XLEN-1:0] == {1'b1, {(XLEN-1){1'b0}}}));

   // R7
   signed_sat_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ovf && sg_d && sat_d && wd_d) |->
      (result == {1'b0, {(2*XLEN-1){1'b1}}} || result == {1'b1, {(2*XLEN-1){1'b0}}}));

   // R8
   unsigned_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ovf && !sg_d && sat_d) |->
      (result[XLEN-1:0] == '0 || result[XLEN-1:0] == '1));

endmodule

bind imac_unit imac_unit_chk #(.XLEN(XLEN), .MUL_REG(MUL_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .is_signed (is_signed),
   .sat_en    (sat_en),
   .wide      (wide),
   .out_valid (out_valid),
   .result    (result),
   .ovf       (ovf)
);

// File: tb/imac_unit_test.sv
`timescale 1ns/1ps
module imac_unit_test;
   localparam int XLEN = 32;
   localparam int MREG = 1;
   localparam int LAT  = 1 + MREG;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [63:0] acc = '0;
   logic        is_signed = 1'b0, sat_en = 1'b0, wide = 1'b0;
   logic [1:0]  op = 2'b00;
   logic        out_valid;
   logic [63:0] result;
   logic        ovf;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   always #2.5 clk = ~clk;

   imac_unit #(.XLEN(XLEN), .MUL_REG(MREG)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
      .acc(acc), .is_signed(is_signed), .sat_en(sat_en), .op(op), .wide(wide),
      .out_valid(out_valid), .result(result), .ovf(ovf));

   // reference from the requirements: exact value in 130 bits, then range rules
   task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [63:0] c,
                        input logic sg, input logic sat, input logic [1:0] o, input logic wd,
                        output logic [63:0] r, output logic ov);
      logic signed [129:0] pa, pb, p, ca, v, hi, lo;
      int d;
      d  = wd ? 64 : 32;
      pa = sg ? $signed({{98{a[31]}}, a}) : $signed({98'd0, a});
      pb = sg ? $signed({{98{b[31]}}, b}) : $signed({98'd0, b});
      p  = pa * pb;
      if (wd) ca = sg ? $signed({{66{c[63]}}, c}) : $signed({66'd0, c});
      else    ca = sg ? $signed({{98{c[31]}}, c[31:0]}) : $signed({98'd0, c[31:0]});
      if (o == 2'b01)      v = ca + p;
      else if (o == 2'b10) v = ca - p;
      else                 v = p;
      if (sg) begin
         hi = (130'sd1 <<< (d-1)) - 130'sd1;
         lo = -(130'sd1 <<< (d-1));
      end else begin
         hi = (130'sd1 <<< d) - 130'sd1;
         lo = 130'sd0;
      end
      ov = (v > hi) || (v < lo);
      if (ov && sat) v = (v > hi) ? hi : lo;
      r = wd ? v[63:0] : {32'd0, v[31:0]};
   endtask

   task automatic apply(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic [63:0] c, input logic sg, input logic sat,
                        input logic [1:0] o, input logic wd);
      logic [63:0] er;
      logic        eo;
      model(a, b, c, sg, sat, o, wd, er, eo);
      @(negedge clk);
      src_a = a; src_b = b; acc = c; is_signed = sg; sat_en = sat; op = o; wide = wd;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (LAT-1) @(negedge clk);
      vectors++;
      if (out_valid !== 1'b1 || result !== er || ovf !== eo) begin
         fails++;
         $display("FAIL %s: got v=%b r=%h o=%b, expected v=1 r=%h o=%b",
                  req, out_valid, result, ovf, er, eo);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      vectors++;
      if (out_valid !== 1'b0 || result !== 64'd0 || ovf !== 1'b0) begin
         fails++;
         $display("FAIL R9 reset: got v=%b r=%h o=%b, expected 0/0/0", out_valid, result, ovf);
      end
   endtask

   task automatic t_mul32();   // R1, R5
      apply("R1", 32'd7, 32'hFFFF_FFFD, 64'hDEAD_BEEF_1234_5678, 1, 0, 2'b00, 0);
      apply("R1", 32'h0001_0000, 32'h0001_0000, 64'd0, 1, 0, 2'b00, 0);
      apply("R1", 32'h1234_5678, 32'h9ABC_DEF0, 64'd0, 0, 0, 2'b11, 0);
      apply("R5", 32'hFFFF_FFFF, 32'd2, 64'd0, 0, 0, 2'b00, 0);
   endtask

   task automatic t_mul64();   // R2
      apply("R2", 32'h8000_0000, 32'h8000_0000, 64'd0, 1, 0, 2'b00, 1);
      apply("R2", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 0, 0, 2'b00, 1);
      apply("R2", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1, 0, 2'b00, 1);
      apply("R2", 32'h8000_0000, 32'h7FFF_FFFF, 64'd0, 1, 1, 2'b00, 1);
   endtask

   task automatic t_madd();    // R3
      apply("R3", 32'd3, 32'd5, 64'hFFFF_FFFF_0000_0010, 1, 0, 2'b01, 0);
      apply("R3", 32'hFFFF_FFFF, 32'd4, 64'h0000_0001_0000_0000, 1, 0, 2'b01, 1);
      apply("R3", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0000_0001_FFFF_FFFF, 0, 0, 2'b01, 1);
   endtask

   task automatic t_msub();    // R4
      apply("R4", 32'd6, 32'd7, 64'd100, 1, 0, 2'b10, 0);
      apply("R4", 32'h0001_0000, 32'h0001_0000, 64'd5, 1, 0, 2'b10, 1);
      apply("R4", 32'd2, 32'd3, 64'd5, 0, 0, 2'b10, 0);
   endtask

   task automatic t_sat_signed(); // R5, R6, R7
      apply("R6", 32'h0001_0000, 32'h0001_0000, 64'd0, 1, 1, 2'b00, 0);
      apply("R6", 32'h0001_0000, 32'hFFFF_0000, 64'd0, 1, 1, 2'b00, 0);
      apply("R6", 32'd1, 32'd1, 64'h0000_0000_7FFF_FFFF, 1, 1, 2'b01, 0);
      apply("R5", 32'd1, 32'd1, 64'h0000_0000_7FFF_FFFF, 1, 0, 2'b01, 0);
      apply("R7", 32'd1, 32'd1, 64'h7FFF_FFFF_FFFF_FFFF, 1, 1, 2'b01, 1);
      apply("R7", 32'd1, 32'd1, 64'h8000_0000_0000_0000, 1, 1, 2'b10, 1);
      apply("R5", 32'd1, 32'd1, 64'h8000_0000_0000_0000, 1, 0, 2'b10, 1);
   endtask

   task automatic t_sat_unsigned(); // R5, R8
      apply("R8", 32'd2, 32'd3, 64'd5, 0, 1, 2'b10, 0);
      apply("R8", 32'd2, 32'd3, 64'd5, 0, 1, 2'b10, 1);
      apply("R8", 32'hFFFF_FFFF, 32'd2, 64'd0, 0, 1, 2'b00, 0);
      apply("R8", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 2'b01, 1);
      apply("R5", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 2'b01, 1);
   endtask

   task automatic t_valid_gap(); // R9
      apply("R9", 32'd9, 32'd9, 64'd0, 0, 0, 2'b00, 0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         vectors++;
         if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R9 idle cycle %0d: got out_valid=%b, expected 0", i, out_valid);
         end
      end
      // result holds while idle
      vectors++;
      if (result !== 64'd81) begin
         fails++;
         $display("FAIL R9 hold: got r=%h, expected %h", result, 64'd81);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_mul32();
      t_mul64();
      t_madd();
      t_msub();
      t_sat_signed();
      t_sat_unsigned();
      t_valid_gap();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule